// File: doc/BRIEF.md
# Field Parity and Line-21 Pulse Generator

This block watches already-digitised horizontal and vertical sync pulses and derives three things from them. It reports whether a stable line rate is present. It decides whether each new field is odd or even, from where the vertical sync arrives inside the current line. It also raises a strobe for the whole of video line 21, where closed-caption and extended-data services are carried, so that a downstream slicer knows when to capture.

One status pin is shared between the sync-present flag and the field parity, under a select input. A mode input restricts the line-21 strobe to even fields or lets it appear in every field. The clock is a plain system clock. The nominal line period, the tolerance, the loss and lock counts and the target line are all parameters.

Top module: `field_line21_gen`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `sync_ok_o`, `field_even_o`, `line21_o` and `status_o` are all low.
- R2: A rising edge of `hsync_i` is a valid line edge when the clocks since the previous rising edge lie in `LINE_CYC-TOL` to `LINE_CYC+TOL` inclusive. On the `LOCK_N`-th (16 by default) consecutive valid edge, `sync_ok_o` goes high one clock after the edge is sampled. The first edge after reset or after a loss is never valid.
- R3: A rising hsync edge whose spacing is outside the window clears the run of consecutive valid edges. It does not change `sync_ok_o`.
- R4: When `MISS_N*LINE_CYC` clocks (4 line periods by default) pass with no hsync rising edge, `sync_ok_o` drops one clock later and the run of valid edges is cleared.
- R5: On a vsync rising edge, the phase is the number of clocks since the last hsync rising edge, or 0 when both edges are sampled in the same clock. A phase in `[LINE_CYC/4, 3*LINE_CYC/4)` makes `field_even_o` 1 (even field). Any other phase makes it 0 (odd field). The output updates one clock later.
- R6: A vsync rising edge sampled while `sync_ok_o` is low leaves `field_even_o` unchanged.
- R7: The line count becomes 0 on a vsync rising edge, or 1 if an hsync rising edge is sampled in the same clock. Otherwise each hsync rising edge adds 1, saturating at the counter maximum.
- R8: `line21_o` is high in exactly the clocks during which the line count equals 21 and `sync_ok_o` is high. With `both_fields_i` low, it is also required that `field_even_o` is 1.
- R9: With `both_fields_i` high, `line21_o` appears on line 21 of odd and even fields alike.
- R10: No `line21_o` is produced while `sync_ok_o` is low, even when the line count passes 21.
- R11: `status_o` equals `sync_ok_o` when `status_sel_i` is 0 and equals `field_even_o` when `status_sel_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync, active high, rising edge marks line start |
| vsync_i | input | 1 | Vertical sync, active high, rising edge marks field start |
| both_fields_i | input | 1 | 0: line-21 strobe in even fields only; 1: in every field |
| status_sel_i | input | 1 | 0: status pin shows sync present; 1: shows field parity |
| field_even_o | output | 1 | 1 = even field, 0 = odd field |
| line21_o | output | 1 | High for the whole of line 21 |
| sync_ok_o | output | 1 | High while a valid line rate is detected |
| status_o | output | 1 | Shared status pin, selected by `status_sel_i` |

## Verification
The parity decision and the line-count restart can coincide with a line-count step, because a vsync rising edge and an hsync rising edge can be sampled in the same clock. The bench provokes this by starting every odd field with vsync aligned exactly on the hsync leading edge. Even fields start with vsync at mid-line. In the coincident case, the field must come out odd, taking phase 0 rather than the stale distance to the previous edge. That edge must also count as line 1, so the strobe lands on the 21st line of the field (index 20) and not one line later. A behavioural model, based on time stamps and compared every clock, judges both effects, and directed checks of the strobe's starting line and length back it up.

// File: rtl/field_line21_pkg.sv
// Package: shared types for the field parity / line-21 generator.
// Assumes: nothing beyond the encoding of field parity below.
package field_line21_pkg;

    // Field parity as carried between the parity and pulse stages
    typedef enum logic {
        FIELD_ODD  = 1'b0,
        FIELD_EVEN = 1'b1
    } field_t;

endpackage

// File: rtl/rise_detect.sv
// Module: rise_detect
// Flags the first clock in which a synchronous input is seen high.
// Assumes the input is already synchronised to clk.
module rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);

    logic sig_q;

    // Keep last sampled level; cleared in reset so a level held high counts once
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_i;
    end

    assign rise_o = sig_i & ~sig_q;

endmodule

// File: rtl/hsync_monitor.sv
// Module: hsync_monitor
// Measures spacing of hsync leading edges, declares sync present after
// LOCK_N consecutive in-window edges and absent after MISS_N silent lines.
// Assumes hs_rise_i is a single-clock pulse per line.
module hsync_monitor #(
    parameter int LINE_CYC = 64,
    parameter int TOL      = 4,
    parameter int MISS_N   = 4,
    parameter int LOCK_N   = 16,
    localparam int LOSS    = MISS_N * LINE_CYC,
    localparam int CNT_W   = $clog2(LOSS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_rise_i,
    output logic [CNT_W-1:0] since_o,
    output logic             sync_ok_o
);

    localparam int LOCK_W = (LOCK_N > 1) ? $clog2(LOCK_N) : 1;
    localparam int WIN_LO = LINE_CYC - TOL;
    localparam int WIN_HI = LINE_CYC + TOL;

    logic [CNT_W-1:0]  cnt_q;
    logic [LOCK_W-1:0] good_q;
    logic              in_window;
    logic              silent;

    // Clocks since the last leading edge, saturating at the loss limit
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt_q <= CNT_W'(LOSS);
        else if (hs_rise_i)           cnt_q <= CNT_W'(1);
        else if (cnt_q < CNT_W'(LOSS)) cnt_q <= cnt_q + CNT_W'(1);
    end

    assign in_window = (cnt_q >= CNT_W'(WIN_LO)) && (cnt_q <= CNT_W'(WIN_HI));
    assign silent    = (cnt_q >= CNT_W'(LOSS));

    // Run length of valid edges and the resulting lock flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            good_q    <= '0;
            sync_ok_o <= 1'b0;
        end else if (hs_rise_i) begin
            if (!in_window)                          good_q    <= '0;
            else if (good_q == LOCK_W'(LOCK_N - 1))  sync_ok_o <= 1'b1;
            else                                     good_q    <= good_q + LOCK_W'(1);
        end else if (silent) begin
            good_q    <= '0;
            sync_ok_o <= 1'b0;
        end
    end

    assign since_o = cnt_q;

    // R2: lock is only ever gained right after a leading edge
    a_r2_lock_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_ok_o) |-> $past(hs_rise_i));

    // R4: a full silent window always leaves sync absent next clock
    a_r4_loss_after_silence: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_rise_i && cnt_q == CNT_W'(LOSS)) |=> !sync_ok_o);

endmodule

// File: rtl/field_parity.sv
// Module: field_parity
// Classifies each field as odd or even from the line phase at which the
// vsync leading edge lands; holds its value while sync is absent.
// Assumes since_i counts clocks from the last hsync leading edge.
module field_parity
    import field_line21_pkg::*;
#(
    parameter int LINE_CYC = 64,
    parameter int CNT_W    = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_rise_i,
    input  logic             vs_rise_i,
    input  logic [CNT_W-1:0] since_i,
    input  logic             sync_ok_i,
    output field_t           field_o
);

    localparam int MID_LO = LINE_CYC / 4;
    localparam int MID_HI = (3 * LINE_CYC) / 4;

    logic [CNT_W-1:0] phase;
    logic             near_mid;

    assign phase    = hs_rise_i ? '0 : since_i;
    assign near_mid = (phase >= CNT_W'(MID_LO)) && (phase < CNT_W'(MID_HI));

    // Latch parity at each field start, only while the line rate is trusted
    always_ff @(posedge clk) begin
        if (!rst_n)                     field_o <= FIELD_ODD;
        else if (vs_rise_i && sync_ok_i) field_o <= near_mid ? FIELD_EVEN : FIELD_ODD;
    end

    // R6: without sync, the parity never moves
    a_r6_hold_without_sync: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_ok_i |=> $stable(field_o));

endmodule

// File: rtl/line_strobe.sv
// Module: line_strobe
// Counts lines from the field start and raises a strobe for the whole of
// the target line, gated by sync presence and by the field-selection mode.
// Assumes vs_rise_i and hs_rise_i are single-clock pulses.
module line_strobe
    import field_line21_pkg::*;
#(
    parameter int LINE_W      = 10,
    parameter int TARGET_LINE = 21
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   hs_rise_i,
    input  logic   vs_rise_i,
    input  logic   sync_ok_i,
    input  field_t field_i,
    input  logic   both_fields_i,
    output logic   strobe_o
);

    localparam logic [LINE_W-1:0] LINE_MAX = '1;

    logic [LINE_W-1:0] line_q;
    logic              field_allowed;

    // Line number within the field; a coincident line edge counts as line 1
    always_ff @(posedge clk) begin
        if (!rst_n)                          line_q <= '0;
        else if (vs_rise_i)                  line_q <= hs_rise_i ? LINE_W'(1) : '0;
        else if (hs_rise_i && line_q != LINE_MAX) line_q <= line_q + LINE_W'(1);
    end

    assign field_allowed = both_fields_i || (field_i == FIELD_EVEN);
    assign strobe_o      = sync_ok_i && field_allowed && (line_q == LINE_W'(TARGET_LINE));

    // R7: a field start always restarts the count at 0 or 1
    a_r7_restart_on_field: assert property (@(posedge clk) disable iff (!rst_n)
        vs_rise_i |=> (line_q <= LINE_W'(1)));

endmodule

// File: rtl/field_line21_gen.sv
// Module: field_line21_gen (top)
// Edge detection on both syncs, line-rate monitor, field parity and the
// line-21 strobe, plus the shared status pin.
// Assumes hsync_i/vsync_i are synchronous to clk and active high.
module field_line21_gen
    import field_line21_pkg::*;
#(
    parameter int LINE_CYC    = 64,
    parameter int TOL         = 4,
    parameter int MISS_N      = 4,
    parameter int LOCK_N      = 16,
    parameter int LINE_W      = 10,
    parameter int TARGET_LINE = 21,
    localparam int CNT_W      = $clog2(MISS_N * LINE_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync_i,
    input  logic vsync_i,
    input  logic both_fields_i,
    input  logic status_sel_i,
    output logic field_even_o,
    output logic line21_o,
    output logic sync_ok_o,
    output logic status_o
);

    logic             hs_rise;
    logic             vs_rise;
    logic [CNT_W-1:0] since;
    field_t           field;

    rise_detect i_hs_edge (.clk(clk), .rst_n(rst_n), .sig_i(hsync_i), .rise_o(hs_rise));
    rise_detect i_vs_edge (.clk(clk), .rst_n(rst_n), .sig_i(vsync_i), .rise_o(vs_rise));

    hsync_monitor #(
        .LINE_CYC(LINE_CYC), .TOL(TOL), .MISS_N(MISS_N), .LOCK_N(LOCK_N)
    ) i_monitor (
        .clk(clk), .rst_n(rst_n), .hs_rise_i(hs_rise),
        .since_o(since), .sync_ok_o(sync_ok_o)
    );

    field_parity #(.LINE_CYC(LINE_CYC), .CNT_W(CNT_W)) i_parity (
        .clk(clk), .rst_n(rst_n), .hs_rise_i(hs_rise), .vs_rise_i(vs_rise),
        .since_i(since), .sync_ok_i(sync_ok_o), .field_o(field)
    );

    line_strobe #(.LINE_W(LINE_W), .TARGET_LINE(TARGET_LINE)) i_strobe (
        .clk(clk), .rst_n(rst_n), .hs_rise_i(hs_rise), .vs_rise_i(vs_rise),
        .sync_ok_i(sync_ok_o), .field_i(field), .both_fields_i(both_fields_i),
        .strobe_o(line21_o)
    );

    assign field_even_o = (field == FIELD_EVEN);
    assign status_o     = status_sel_i ? field_even_o : sync_ok_o;

    // R10: the strobe never shows while the monitor reports no sync
    a_r10_no_strobe_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_ok_o |-> !line21_o);

endmodule

// File: tb/test_field_line21_gen.sv
`timescale 1ns/1ps
// Bench: behavioural time-stamp model compared every clock, plus directed checks.
module test_field_line21_gen;

    localparam int L    = 64;
    localparam int T    = 4;
    localparam int LOSS = 4 * L;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hsync_i = 1'b0, vsync_i = 1'b0, both_fields_i = 1'b0, status_sel_i = 1'b0;
    logic field_even_o, line21_o, sync_ok_o, status_o;

    field_line21_gen i_field_line21_gen (
        .clk(clk), .rst_n(rst_n), .hsync_i(hsync_i), .vsync_i(vsync_i),
        .both_fields_i(both_fields_i), .status_sel_i(status_sel_i),
        .field_even_o(field_even_o), .line21_o(line21_o),
        .sync_ok_o(sync_ok_o), .status_o(status_o)
    );

    always #2.5 clk = ~clk;

    int    n_checks = 0, n_err = 0;
    string cur_req = "R1";
    int    p_cnt = 0, first_line = -1, cur_line = 0;

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model: time stamps and counts, updated per clock
    int m_t, m_last, m_good, m_line;
    bit m_phs, m_pvs, m_ok, m_even;

    always @(posedge clk) begin
        bit hr, vr;
        int since, ph;
        if (!rst_n) begin
            m_t = 0; m_last = -1; m_good = 0; m_line = 0;
            m_phs = 0; m_pvs = 0; m_ok = 0; m_even = 0;
        end else begin
            hr = hsync_i && !m_phs;
            vr = vsync_i && !m_pvs;
            since = (m_last < 0) ? LOSS : ((m_t - m_last) > LOSS ? LOSS : (m_t - m_last));
            if (vr && m_ok) begin
                ph = hr ? 0 : since;
                m_even = (ph >= L / 4) && (ph < (3 * L) / 4);
            end
            if (hr) begin
                if (since >= L - T && since <= L + T) begin
                    m_good++;
                    if (m_good >= 16) m_ok = 1;
                end else m_good = 0;
                m_last = m_t;
            end else if (since >= LOSS) begin
                m_ok = 0; m_good = 0;
            end
            if (vr) m_line = hr ? 1 : 0;
            else if (hr && m_line < 1023) m_line++;
            m_phs = hsync_i; m_pvs = vsync_i;
            m_t++;
        end
        #1;
        chk(cur_req, "sync_ok_o", sync_ok_o, m_ok);
        chk(cur_req, "field_even_o", field_even_o, m_even);
        chk(cur_req, "line21_o", line21_o, m_ok && m_line == 21 && (both_fields_i || m_even));
        chk(cur_req, "status_o", status_o, status_sel_i ? m_even : m_ok);
        if (line21_o) begin
            p_cnt++;
            if (first_line < 0) first_line = cur_line;
        end
    end

    task automatic run_line(int len, int vs_off, bit hs_on);
        for (int c = 0; c < len; c++) begin
            @(negedge clk);
            hsync_i = hs_on && (c < 4);
            vsync_i = (vs_off >= 0) && (c >= vs_off);
        end
    endtask

    task automatic run_field(int n, int vs_off);
        p_cnt = 0; first_line = -1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cur_line = k;
            hsync_i = 1'b1;
            vsync_i = (k == 0) && (vs_off == 0);
            run_line(L - 1, (k == 0 && vs_off > 0) ? vs_off - 1 : -1, 1'b1);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: outputs right after reset release
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", "sync_ok_o", sync_ok_o, 0);
        chk("R1", "line21_o", line21_o, 0);
        chk("R1", "field_even_o", field_even_o, 0);
        chk("R1", "status_o", status_o, 0);

        cur_req = "R2";
        repeat (20) run_line(L, -1, 1'b1);
        chk("R2", "locked after 20 lines", sync_ok_o, 1);

        // R5/R8: odd field (vsync coincident with hsync), then even field, even-only mode
        cur_req = "R8"; both_fields_i = 1'b0; status_sel_i = 1'b1;
        run_field(262, 0);
        chk("R5", "odd field on coincident edges", field_even_o, 0);
        chk("R8", "no strobe in odd field", p_cnt, 0);
        run_field(263, L / 2);
        chk("R5", "even field at mid-line", field_even_o, 1);
        chk("R8", "strobe length even field", p_cnt, L);
        chk("R7", "strobe line after mid-line start", first_line, 21);
        chk("R11", "status shows parity", status_o, 1);

        // R9: both fields, status shows sync flag
        cur_req = "R9"; both_fields_i = 1'b1; status_sel_i = 1'b0;
        run_field(262, 0);
        chk("R9", "strobe length odd field", p_cnt, L);
        chk("R7", "coincident edge counts as line 1", first_line, 20);
        run_field(263, L / 2);
        chk("R9", "strobe length even field", p_cnt, L);
        chk("R11", "status shows sync flag", status_o, 1);

        // R4: silence drops sync; R6: vsync while absent leaves parity (even)
        cur_req = "R4";
        repeat (5) run_line(L, -1, 1'b0);
        chk("R4", "sync lost after silence", sync_ok_o, 0);
        cur_req = "R6";
        run_line(L, 0, 1'b0);
        chk("R6", "parity held", field_even_o, 1);

        // R3/R10: relock interrupted by a short line; line 21 passes unlocked
        cur_req = "R10"; p_cnt = 0;
        run_line(L, L / 2, 1'b1);
        repeat (9) run_line(L, -1, 1'b1);
        run_line(40, -1, 1'b1);
        repeat (12) run_line(L, -1, 1'b1);
        chk("R3", "short line restarted lock count", sync_ok_o, 0);
        chk("R10", "no strobe while unlocked", p_cnt, 0);
        repeat (8) run_line(L, -1, 1'b1);
        chk("R3", "locked after 16 valid edges", sync_ok_o, 1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule